// File: doc/BRIEF.md
# Configuration Image Parity Scanner

This block walks a small nonvolatile configuration image that sits in a register array. The image is ten lines of 16 bits at word addresses 0x10 to 0x19. The block checks every line for odd parity and checks every bit column against a parity rule that alternates from column to column. The first line, at 0x10, carries the column parity bits, and bit 15 of each line is that line's own parity bit.

A one-cycle `start` pulse launches a scan. The scanner then drives `rd_addr` through the ten lines, one per clock, and reads `rd_data` in the same cycle, since the array answers combinationally. Eleven cycles after the start it raises `done` for one cycle. In that same cycle it publishes four results:
- the low four address bits of the first line that failed, or the value 0xF when every line is good;
- a flag that is set when more than one line failed;
- a flag that is set when any column failed;
- a lock indication taken from two lock bits inside the image.

These results then stay unchanged until the next scan completes.

Top module: `parity_scan_checker`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `done`, `err_multi`, `col_err` and `lock` are 0, `err_addr` is 4'hF and `rd_addr` is 0x10.
- R2: After an accepted start, `rd_addr` reads 0x10+k in the k-th cycle after the start edge, for k = 0 to 9. Once the scan ends it returns to 0x10 and holds there.
- R3: `done` is high for exactly one cycle. It is set on the 11th rising edge after the edge that sampled an accepted `start`.
- R4: A line fails when its 16 bits, including its parity bit in bit 15, hold an even number of ones.
- R5: At `done`, `err_addr` takes the low 4 bits of the address of the lowest failing line (0x10 gives 0x0, 0x19 gives 0x9), or 4'hF when no line fails.
- R6: At `done`, `err_multi` is 1 exactly when two or more lines failed.
- R7: At `done`, `col_err` is 1 exactly when some column j breaks its rule. Take the XOR of bit j over all ten lines: it must be 0 for even j and 1 for odd j.
- R8: At `done`, `lock` is 1 exactly when bit 14 of line 0x11 is 1 or bit 0 of line 0x16 is 0.
- R9: `err_addr`, `err_multi`, `col_err` and `lock` change only in the cycle where `done` is high. A `start` that arrives while a scan is running is ignored and does not move the `done` timing. A `start` in the cycle where `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to scan the image |
| rd_data | input | 16 | Line contents at `rd_addr`, combinational from the array |
| rd_addr | output | 6 | Word address of the line being read |
| done | output | 1 | One-cycle pulse marking the end of a scan |
| err_addr | output | 4 | Low address bits of the first failing line, 0xF if none |
| err_multi | output | 1 | More than one line failed |
| col_err | output | 1 | At least one column broke its parity rule |
| lock | output | 1 | Image lock bits indicate a locked state |

## Verification
The bench builds the block with its default parameters: ten lines of 16 bits at base 0x10, lock bits at line 1 bit 14 and line 6 bit 0. With these values every line tag from 0x0 to 0x9 and the 0xF sentinel can be reached, and so can the column 15 rule, which involves only parity bits.

Repaired images are then damaged on purpose in four ways:
- a single bit is flipped in the first or the last line;
- two lines are damaged in the same column, so that the line error is raised while the columns cancel out;
- two bits are flipped in one line, so that only the column error is raised;
- a start arrives while a scan is running, or in the cycle where the previous scan finishes.

// File: rtl/pscan_pkg.sv
package pscan_pkg;

  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_SCAN  = 2'd1,
    SC_FINAL = 2'd2
  } scan_state_e;

  localparam logic [3:0] TAG_NONE = 4'hF;

endpackage

// File: rtl/pscan_seq.sv
module pscan_seq
  import pscan_pkg::*;
#(
  parameter int NUM_LINES = 10,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic [IDX_W-1:0] idx,
  output logic             clear,
  output logic             sample,
  output logic             wrap_up
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

  scan_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SC_IDLE;
      idx   <= '0;
    end else begin
      unique case (state)
        SC_IDLE: begin
          if (start) begin
            state <= SC_SCAN;
            idx   <= '0;
          end
        end
        SC_SCAN: begin
          if (idx == LAST_IDX) begin
            state <= SC_FINAL;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        SC_FINAL: state <= SC_IDLE;
        default:  state <= SC_IDLE;
      endcase
    end
  end

  assign clear   = (state == SC_IDLE) && start;
  assign sample  = (state == SC_SCAN);
  assign wrap_up = (state == SC_FINAL);

endmodule

// File: rtl/pscan_col_acc.sv
module pscan_col_acc #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             sample,
  input  logic [WIDTH-1:0] data,
  output logic             col_bad
);

  logic [WIDTH-1:0] acc;
  logic [WIDTH-1:0] expect_x;

  for (genvar j = 0; j < WIDTH; j++) begin : g_exp
    assign expect_x[j] = (j % 2 == 1);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc <= '0;
    end else if (sample) begin
      acc <= acc ^ data;
    end
  end

  assign col_bad = |(acc ^ expect_x);

endmodule

// File: rtl/pscan_line_track.sv
module pscan_line_track #(
  parameter int WIDTH = 16,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             sample,
  input  logic [WIDTH-1:0] data,
  input  logic [TAG_W-1:0] tag,
  output logic             seen,
  output logic [TAG_W-1:0] first_tag,
  output logic             multi
);

  logic line_bad;

  assign line_bad = ~(^data);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      seen      <= 1'b0;
      first_tag <= '0;
      multi     <= 1'b0;
    end else if (sample && line_bad) begin
      if (!seen) begin
        seen      <= 1'b1;
        first_tag <= tag;
      end else begin
        multi <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pscan_lock_cap.sv
module pscan_lock_cap #(
  parameter int WIDTH       = 16,
  parameter int IDX_W       = 4,
  parameter int HI_LINE     = 1,
  parameter int HI_BIT      = 14,
  parameter int LO_LINE     = 6,
  parameter int LO_BIT      = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             sample,
  input  logic [IDX_W-1:0] idx,
  input  logic [WIDTH-1:0] data,
  output logic             locked
);

  localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(HI_LINE);
  localparam logic [IDX_W-1:0] LO_IDX = IDX_W'(LO_LINE);

  logic hi_q;
  logic lo_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      hi_q <= 1'b0;
      lo_q <= 1'b1;
    end else if (sample) begin
      if (idx == HI_IDX) hi_q <= data[HI_BIT];
      if (idx == LO_IDX) lo_q <= data[LO_BIT];
    end
  end

  assign locked = hi_q | ~lo_q;

endmodule

// File: rtl/parity_scan_checker.sv
module parity_scan_checker
  import pscan_pkg::*;
#(
  parameter int NUM_LINES = 10,
  parameter int WIDTH     = 16,
  parameter int ADDR_W    = 6,
  parameter int BASE_ADDR = 16,
  parameter int TAG_W     = 4,
  parameter int HI_LINE   = 1,
  parameter int HI_BIT    = 14,
  parameter int LO_LINE   = 6,
  parameter int LO_BIT    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WIDTH-1:0]  rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              done,
  output logic [TAG_W-1:0]  err_addr,
  output logic              err_multi,
  output logic              col_err,
  output logic              lock
);

  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);

  logic [IDX_W-1:0] idx;
  logic             clear;
  logic             sample;
  logic             wrap_up;
  logic             col_bad;
  logic             seen;
  logic [TAG_W-1:0] first_tag;
  logic             multi;
  logic             locked;

  pscan_seq #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .idx(idx),
    .clear(clear), .sample(sample), .wrap_up(wrap_up)
  );

  assign rd_addr = BASE_A + ADDR_W'(idx);

  pscan_col_acc #(.WIDTH(WIDTH)) u_col (
    .clk(clk), .rst(rst), .clear(clear), .sample(sample),
    .data(rd_data), .col_bad(col_bad)
  );

  pscan_line_track #(.WIDTH(WIDTH), .TAG_W(TAG_W)) u_line (
    .clk(clk), .rst(rst), .clear(clear), .sample(sample),
    .data(rd_data), .tag(rd_addr[TAG_W-1:0]),
    .seen(seen), .first_tag(first_tag), .multi(multi)
  );

  pscan_lock_cap #(
    .WIDTH(WIDTH), .IDX_W(IDX_W), .HI_LINE(HI_LINE), .HI_BIT(HI_BIT),
    .LO_LINE(LO_LINE), .LO_BIT(LO_BIT)
  ) u_lock (
    .clk(clk), .rst(rst), .clear(clear), .sample(sample),
    .idx(idx), .data(rd_data), .locked(locked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      err_addr  <= TAG_W'(TAG_NONE);
      err_multi <= 1'b0;
      col_err   <= 1'b0;
      lock      <= 1'b0;
    end else begin
      done <= wrap_up;
      if (wrap_up) begin
        err_addr  <= seen ? first_tag : TAG_W'(TAG_NONE);
        err_multi <= multi;
        col_err   <= col_bad;
        lock      <= locked;
      end
    end
  end

endmodule

// File: rtl/pscan_chk.sv
module pscan_chk #(
  parameter int NUM_LINES = 10,
  parameter int ADDR_W    = 6,
  parameter int BASE_ADDR = 16,
  parameter int TAG_W     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              done,
  input logic [TAG_W-1:0]  err_addr,
  input logic              err_multi,
  input logic              col_err,
  input logic              lock
);

  logic     c_busy;
  int unsigned c_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_busy <= 1'b0;
      c_cnt  <= 0;
    end else if (start && (!c_busy || done)) begin
      c_busy <= 1'b1;
      c_cnt  <= 0;
    end else if (done) begin
      c_busy <= 1'b0;
    end else if (c_busy) begin
      c_cnt <= c_cnt + 1;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3
  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (rst)
    done |-> (c_busy && c_cnt == NUM_LINES + 1)); // R3
  AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_addr) >= BASE_ADDR) && (int'(rd_addr) < BASE_ADDR + NUM_LINES)); // R2
  AST_TAG_RANGE: assert property (@(posedge clk) disable iff (rst)
    (err_addr != {TAG_W{1'b1}}) |-> (int'(err_addr) < NUM_LINES)); // R5
  AST_MULTI_HAS_FIRST: assert property (@(posedge clk) disable iff (rst)
    err_multi |-> (err_addr != {TAG_W{1'b1}})); // R6
  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(err_addr) && $stable(err_multi) && $stable(col_err))); // R9
  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(lock)); // R8

endmodule

bind parity_scan_checker pscan_chk #(
  .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .TAG_W(TAG_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .rd_addr(rd_addr), .done(done),
  .err_addr(err_addr), .err_multi(err_multi), .col_err(col_err), .lock(lock)
);

// File: tb/parity_scan_checker_test.sv
module parity_scan_checker_test;

  localparam int NL = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] rd_data;
  logic [5:0]  rd_addr;
  logic        done;
  logic [3:0]  err_addr;
  logic        err_multi;
  logic        col_err;
  logic        lock;

  logic [15:0] img [0:NL-1];

  int vectors = 0;
  int fails   = 0;
  bit running = 1'b0;

  always #4 clk = ~clk;

  parity_scan_checker uut (
    .clk(clk), .rst(rst), .start(start), .rd_data(rd_data), .rd_addr(rd_addr),
    .done(done), .err_addr(err_addr), .err_multi(err_multi),
    .col_err(col_err), .lock(lock)
  );

  always_comb begin
    int k;
    k = int'(rd_addr) - 16;
    rd_data = (k >= 0 && k < NL) ? img[k] : 16'h0000;
  end

  // ---------------- reference model ----------------
  bit   m_busy, m_done, m_multi, m_col, m_lock;
  int   m_cnt;
  logic [3:0] m_err;
  logic [3:0] p_err;
  bit   p_multi, p_col, p_lock;

  task automatic predict();
    int nbad;
    int first;
    logic [15:0] cx;
    nbad = 0; first = -1; cx = 16'h0;
    for (int l = 0; l < NL; l++) begin
      cx = cx ^ img[l];
      if (($countones(img[l]) % 2) == 0) begin   // R4
        nbad++;
        if (first < 0) first = l;
      end
    end
    p_err   = (first < 0) ? 4'hF : 4'((16 + first) % 16);
    p_multi = (nbad > 1);
    p_col   = (cx != 16'hAAAA);
    p_lock  = img[1][14] || !img[6][0];
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_cnt = 0; m_done = 0;
      m_err = 4'hF; m_multi = 0; m_col = 0; m_lock = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_cnt == NL) begin
          m_done = 1; m_busy = 0;
          m_err = p_err; m_multi = p_multi; m_col = p_col; m_lock = p_lock;
        end else begin
          m_cnt++;
        end
      end else if (start) begin
        predict();
        m_busy = 1; m_cnt = 0;
      end
    end
  end

  task automatic cmp1(input string req, input int act, input int exp_v);
    vectors++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      int ea;
      ea = 16 + ((m_busy && m_cnt < NL) ? m_cnt : 0);
      cmp1(rst ? "R1 rd_addr" : "R2 rd_addr", int'(rd_addr), ea);
      cmp1(rst ? "R1 done" : "R3 done", int'(done), int'(m_done));
      cmp1(m_done ? "R4/R5 err_addr" : "R9 err_addr held", int'(err_addr), int'(m_err));
      cmp1(m_done ? "R6 err_multi" : "R9 err_multi held", int'(err_multi), int'(m_multi));
      cmp1(m_done ? "R7 col_err" : "R9 col_err held", int'(col_err), int'(m_col));
      cmp1(m_done ? "R8 lock" : "R9 lock held", int'(lock), int'(m_lock));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic fix_parity();
    for (int l = 1; l < NL; l++) img[l][15] = ~(^img[l][14:0]);
    for (int c = 0; c < 15; c++) begin
      logic x;
      x = 1'b0;
      for (int l = 1; l < NL; l++) x = x ^ img[l][c];
      img[0][c] = x ^ logic'(c % 2);
    end
    img[0][15] = ~(^img[0][14:0]);
  endtask

  task automatic fill(input bit hi, input bit lo);
    for (int l = 0; l < NL; l++) img[l] = 16'($urandom);
    img[1][14] = hi;
    img[6][0]  = lo;
    fix_parity();
  endtask

  // pulse start; returns at the negedge where done is visible
  task automatic scan();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (11) @(negedge clk);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    fill(1'b0, 1'b1);
    running = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);  // R1 first cycle after reset compared by the model

    scan(); @(negedge clk);                          // clean image, no lock
    fill(1'b0, 1'b1); img[3][5] ^= 1'b1;  scan(); @(negedge clk);  // R4 R5 R7
    fill(1'b0, 1'b1); img[0][15] ^= 1'b1; scan(); @(negedge clk);  // R5 tag 0
    fill(1'b0, 1'b1); img[9][2] ^= 1'b1;  scan(); @(negedge clk);  // R5 tag 9
    fill(1'b0, 1'b1); img[2][7] ^= 1'b1; img[8][7] ^= 1'b1;
    scan(); @(negedge clk);                          // R6 with columns clean
    fill(1'b0, 1'b1); img[9][0] ^= 1'b1; img[9][1] ^= 1'b1;
    scan(); @(negedge clk);                          // R7 only
    fill(1'b1, 1'b1); scan(); @(negedge clk);        // R8 high lock bit
    fill(1'b0, 1'b0); scan(); @(negedge clk);        // R8 low lock bit
    fill(1'b1, 1'b0); scan(); @(negedge clk);        // R8 both

    // R9: start while busy is ignored
    fill(1'b0, 1'b1); img[4][11] ^= 1'b1;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (7) @(negedge clk);
    @(negedge clk);

    // R9: back-to-back, start in the done cycle is accepted
    fill(1'b0, 1'b1); scan();
    scan();
    repeat (3) @(negedge clk);

    for (int n = 0; n < 20; n++) begin
      fill(1'($urandom), 1'($urandom));
      for (int f = 0; f < int'($urandom % 4); f++)
        img[$urandom % NL][$urandom % 16] ^= 1'b1;
      scan();
      @(negedge clk);
    end

    repeat (4) @(negedge clk);
    running = 1'b0;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule